// File: doc/BRIEF.md
# Multi-Rate TDM Time-Slot Interchanger

This block switches eight-bit voice channels between twelve serial PCM links that share one 8.192 MHz frame clock. Two input links run at the full rate of one bit per clock, giving 128 slots per 125 µs frame. One of them is the return path from a conference bridge and the other carries tone and announcement samples. Ten more input links run at a quarter of that rate, one bit every four clocks, giving 32 slots per frame. On the output side there is one full-rate link toward the conference bridge and eleven quarter-rate links.

Every received byte goes into a speech store that has two halves. During each frame the incoming bytes fill one half while the outputs read from the other half. The halves swap on frame sync, so every connection has exactly one frame of delay. For each output slot, a connection store entry names the source slot. If the entry is switched off, the slot carries the idle byte 0xD5 instead. A host fills the connection store through a simple write port, one entry per clock. The switch is non-blocking: any input slot can feed any number of output slots.

Top module: `tsi_switch`

## Requirements
- R1: While `rst` is high, every serial output is low. Reset turns off every connection entry, so after reset every output slot carries 0xD5 until the host programs it.
- R2: `frameSync` is high in the cycle that carries bit 7 of slot 0 on every input link. Serial data is sent MSB first. A full-rate link moves one bit per clock (slot = position/8). A quarter-rate link holds each bit for four clocks (slot = position/32). Each output bit appears one clock after the matching input frame position.
- R3: A full-rate output slot reproduces the byte from a chosen full-rate input slot.
- R4: A quarter-rate output slot reproduces the byte from a chosen quarter-rate input slot, up to and including the last link and the last slot.
- R5: Switching works across rates, from full-rate to quarter-rate and from quarter-rate to full-rate.
- R6: An output slot whose entry is switched off carries 0xD5.
- R7: The byte received in frame k appears in frame k+1. This holds whether the output slot comes earlier or later in the frame than the source slot.
- R8: One input slot can feed several output slots in the same frame.
- R9: A host write stores the entry at address {output link position[3:0], slot[6:0]}. The entry is an enable bit plus the source {input link position[3:0], slot[6:0]}. It takes effect from the next clock, so a rewrite can switch a slot off or give it a new source. Input link positions: 0 = conference return, 1 = tone, 2 to 11 = quarter-rate inputs 0 to 9. Output link positions: 0 = conference feed, 1 to 11 = quarter-rate outputs 0 to 10. Quarter-rate slot numbers use the low five bits, with bits 6:5 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 8.192 MHz core clock, one full-rate bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frameSync | input | 1 | Marks frame position 0 (bit 7 of slot 0) |
| fastIn | input | 2 | Full-rate serial inputs (conference return, tone) |
| slowIn | input | 10 | Quarter-rate serial inputs |
| fastOut | output | 1 | Full-rate serial output (conference feed) |
| slowOut | output | 11 | Quarter-rate serial outputs |
| hostWrEn | input | 1 | Connection store write strobe |
| hostWrAddr | input | 11 | Output slot address {link, slot} |
| hostWrOn | input | 1 | Enable bit of the written entry |
| hostWrSrc | input | 11 | Source slot address {link, slot} |

## Verification
The hardest case to reach from the ports is the boundary between frames. A byte written near the very end of one frame must be read back in an output slot near the start of the next frame, after the speech halves have swapped. The stimulus creates this case by routing the last slot of one link to slot 0 of another, and slot 31 of a quarter-rate input to early full-rate slot 5. It also routes a late output from an early input, so that a read of the same frame's data would give a different byte than the expected one-frame delay. Every frame carries data derived from its own frame number, so a read from the wrong half always shows up as a mismatch.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int FAST_SLOTS = 128;
  localparam int RATE_DIV   = 4;
  localparam int BYTE_W     = 8;
  localparam int LINK_POS   = 16;

  localparam int SLOW_SLOTS = FAST_SLOTS / RATE_DIV;
  localparam int FRAME_LEN  = FAST_SLOTS * BYTE_W;
  localparam int POS_W      = $clog2(FRAME_LEN);
  localparam int SLOT_W     = $clog2(FAST_SLOTS);
  localparam int SSLOT_W    = $clog2(SLOW_SLOTS);
  localparam int LINK_W     = $clog2(LINK_POS);
  localparam int ADDR_W     = LINK_W + SLOT_W;
  localparam int BIT_W      = $clog2(BYTE_W);
  localparam int DIV_W      = $clog2(RATE_DIV);

  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hD5;

  typedef struct packed {
    logic [POS_W-1:0] pos;
    logic             wrHalf;
    logic             slowShift;
    logic             fastDone;
    logic             slowDone;
  } tsiStrobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frameSync,
  output tsiStrobe_t strb
);
  logic [POS_W-1:0] cnt;
  logic [POS_W-1:0] pos;
  logic             halfReg;
  logic             curHalf;

  always_comb begin
    pos     = frameSync ? '0 : cnt;
    curHalf = frameSync ? ~halfReg : halfReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      halfReg <= 1'b0;
    end else begin
      cnt     <= pos + 1'b1;
      halfReg <= curHalf;
    end
  end

  always_comb begin
    strb.pos       = pos;
    strb.wrHalf    = curHalf;
    strb.slowShift = (pos[DIV_W-1:0] == '0);
    strb.fastDone  = (pos[BIT_W-1:0] == '1);
    strb.slowDone  = (pos[BIT_W+DIV_W-1:DIV_W] == '1) && (pos[DIV_W-1:0] == '0);
  end

  // R2: frame sync realigns the position counter
  assert_sync_realign_R2: assert property (@(posedge clk) disable iff (rst)
    frameSync |=> (frameSync || strb.pos == POS_W'(1)));

  // R7: speech halves swap on every frame sync
  assert_half_swap_R7: assert property (@(posedge clk) disable iff (rst)
    frameSync |=> (halfReg != $past(halfReg)));
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int N_FAST_IN  = 2,
  parameter int N_SLOW_IN  = 10,
  parameter int N_FAST_OUT = 1,
  parameter int N_SLOW_OUT = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  tsiStrobe_t            strb,
  input  logic [N_FAST_IN-1:0]  fastIn,
  input  logic [N_SLOW_IN-1:0]  slowIn,
  output logic [N_FAST_OUT-1:0] fastOut,
  output logic [N_SLOW_OUT-1:0] slowOut,
  input  logic                  hostWrEn,
  input  logic [ADDR_W-1:0]     hostWrAddr,
  input  logic                  hostWrOn,
  input  logic [ADDR_W-1:0]     hostWrSrc
);
  localparam int MEM_DEPTH = 2 ** ADDR_W;
  localparam int PAD_W     = SLOT_W - SSLOT_W;

  logic [SLOT_W-1:0]  fastSlot;
  logic [SSLOT_W-1:0] slowSlot;
  logic [BIT_W-1:0]   fastBitIdx;
  logic [BIT_W-1:0]   slowBitIdx;

  always_comb begin
    fastSlot   = strb.pos[POS_W-1:BIT_W];
    slowSlot   = strb.pos[POS_W-1:BIT_W+DIV_W];
    fastBitIdx = ~strb.pos[BIT_W-1:0];
    slowBitIdx = ~strb.pos[BIT_W+DIV_W-1:DIV_W];
  end

  // receive shift registers hold the first seven bits of the byte
  logic [BYTE_W-2:0] fastSr [N_FAST_IN];
  logic [BYTE_W-2:0] slowSr [N_SLOW_IN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_FAST_IN; i++) fastSr[i] <= '0;
      for (int j = 0; j < N_SLOW_IN; j++) slowSr[j] <= '0;
    end else begin
      for (int i = 0; i < N_FAST_IN; i++) fastSr[i] <= {fastSr[i][BYTE_W-3:0], fastIn[i]};
      if (strb.slowShift)
        for (int j = 0; j < N_SLOW_IN; j++) slowSr[j] <= {slowSr[j][BYTE_W-3:0], slowIn[j]};
    end
  end

  // double-buffered speech store, index {half, link, slot}
  logic [BYTE_W-1:0] speech [2*MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (strb.fastDone)
      for (int i = 0; i < N_FAST_IN; i++)
        speech[{strb.wrHalf, LINK_W'(i), fastSlot}] <= {fastSr[i], fastIn[i]};
    if (strb.slowDone)
      for (int j = 0; j < N_SLOW_IN; j++)
        speech[{strb.wrHalf, LINK_W'(N_FAST_IN + j), {PAD_W{1'b0}}, slowSlot}] <= {slowSr[j], slowIn[j]};
  end

  // connection store
  logic [ADDR_W-1:0]    cmSrc [MEM_DEPTH];
  logic [MEM_DEPTH-1:0] cmOn;

  always_ff @(posedge clk) begin
    if (rst) cmOn <= '0;
    else if (hostWrEn) cmOn[hostWrAddr] <= hostWrOn;
  end

  always_ff @(posedge clk) begin
    if (hostWrEn) cmSrc[hostWrAddr] <= hostWrSrc;
  end

  // read side
  logic [N_FAST_OUT-1:0]             fastOn;
  logic [N_FAST_OUT-1:0][BYTE_W-1:0] fastByte;
  logic [N_SLOW_OUT-1:0]             slowOn;
  logic [N_SLOW_OUT-1:0][BYTE_W-1:0] slowByte;

  for (genvar k = 0; k < N_FAST_OUT; k++) begin : gFastRd
    logic [ADDR_W-1:0] rdAddr;
    assign rdAddr      = {LINK_W'(k), fastSlot};
    assign fastOn[k]   = cmOn[rdAddr];
    assign fastByte[k] = fastOn[k] ? speech[{~strb.wrHalf, cmSrc[rdAddr]}] : IDLE_BYTE;
  end

  for (genvar m = 0; m < N_SLOW_OUT; m++) begin : gSlowRd
    logic [ADDR_W-1:0] rdAddr;
    assign rdAddr      = {LINK_W'(N_FAST_OUT + m), {PAD_W{1'b0}}, slowSlot};
    assign slowOn[m]   = cmOn[rdAddr];
    assign slowByte[m] = slowOn[m] ? speech[{~strb.wrHalf, cmSrc[rdAddr]}] : IDLE_BYTE;
  end

  logic [N_FAST_OUT-1:0] fastOutReg;
  logic [N_SLOW_OUT-1:0] slowOutReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      fastOutReg <= '0;
      slowOutReg <= '0;
    end else begin
      for (int k = 0; k < N_FAST_OUT; k++) fastOutReg[k] <= fastByte[k][fastBitIdx];
      for (int m = 0; m < N_SLOW_OUT; m++) slowOutReg[m] <= slowByte[m][slowBitIdx];
    end
  end

  assign fastOut = fastOutReg;
  assign slowOut = slowOutReg;

  // R6: a switched-off full-rate slot sends the idle pattern
  assert_idle_fill_R6: assert property (@(posedge clk) disable iff (rst)
    !fastOn[0] |=> fastOutReg[0] == IDLE_BYTE[~$past(strb.pos[BIT_W-1:0])]);

  // R9: a host write is visible on the next clock
  assert_host_write_R9: assert property (@(posedge clk) disable iff (rst)
    hostWrEn |=> (cmOn[$past(hostWrAddr)] == $past(hostWrOn)));

  // R2: a quarter-rate bit is held for all clocks of its bit period
  assert_slow_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.pos[DIV_W-1:0] != '0 && !$past(hostWrEn)) |=> $stable(slowOutReg[0]));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int N_FAST_IN  = 2,
  parameter int N_SLOW_IN  = 10,
  parameter int N_FAST_OUT = 1,
  parameter int N_SLOW_OUT = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frameSync,
  input  logic [N_FAST_IN-1:0]  fastIn,
  input  logic [N_SLOW_IN-1:0]  slowIn,
  output logic [N_FAST_OUT-1:0] fastOut,
  output logic [N_SLOW_OUT-1:0] slowOut,
  input  logic                  hostWrEn,
  input  logic [ADDR_W-1:0]     hostWrAddr,
  input  logic                  hostWrOn,
  input  logic [ADDR_W-1:0]     hostWrSrc
);
  tsiStrobe_t strb;

  tsi_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .frameSync (frameSync),
    .strb      (strb)
  );

  tsi_datapath #(
    .N_FAST_IN  (N_FAST_IN),
    .N_SLOW_IN  (N_SLOW_IN),
    .N_FAST_OUT (N_FAST_OUT),
    .N_SLOW_OUT (N_SLOW_OUT)
  ) uData (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .fastIn     (fastIn),
    .slowIn     (slowIn),
    .fastOut    (fastOut),
    .slowOut    (slowOut),
    .hostWrEn   (hostWrEn),
    .hostWrAddr (hostWrAddr),
    .hostWrOn   (hostWrOn),
    .hostWrSrc  (hostWrSrc)
  );
endmodule

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int CLK_PERIOD = 122;
  localparam int FRAME      = 1024;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        frameSync;
  logic [1:0]  fastIn;
  logic [9:0]  slowIn;
  logic [0:0]  fastOut;
  logic [10:0] slowOut;
  logic        hostWrEn;
  logic [10:0] hostWrAddr;
  logic        hostWrOn;
  logic [10:0] hostWrSrc;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_switch dut (
    .clk(clk), .rst(rst), .frameSync(frameSync), .fastIn(fastIn), .slowIn(slowIn),
    .fastOut(fastOut), .slowOut(slowOut), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .hostWrOn(hostWrOn), .hostWrSrc(hostWrSrc)
  );

  typedef struct {
    int          frame;
    int          outPos;
    int          slot;
    logic [7:0]  exp;
    string       req;
  } expItem_t;

  expItem_t   sbq[$];
  int         testsRun = 0;
  int         testsFailed = 0;
  int         curFrame = 0;
  int         curPos = 0;
  bit         started = 0;
  logic [7:0] capByte [12][128];

  function automatic logic [7:0] dataOf(int f, int p, int s);
    return 8'(f * 29 + p * 17 + s * 3 + 7);
  endfunction

  task automatic expectRoute(int f, int op, int os, int sp, int ss, string req);
    expItem_t it;
    it = '{f, op, os, dataOf(f - 1, sp, ss), req};
    sbq.push_back(it);
  endtask

  task automatic expectIdle(int f, int op, int os, string req);
    expItem_t it;
    it = '{f, op, os, 8'hD5, req};
    sbq.push_back(it);
  endtask

  task automatic scoreFrame(int f);
    while (sbq.size() > 0 && sbq[0].frame == f) begin
      expItem_t it;
      it = sbq.pop_front();
      testsRun++;
      if (capByte[it.outPos][it.slot] !== it.exp) begin
        testsFailed++;
        $display("FAIL %s frame %0d out %0d slot %0d: got %h expected %h",
                 it.req, f, it.outPos, it.slot, capByte[it.outPos][it.slot], it.exp);
      end
    end
  endtask

  // monitor then driver, both away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      started   = 0;
      frameSync = 1'b0;
      fastIn    = '0;
      slowIn    = '0;
    end else begin
      if (started) begin
        capByte[0][curPos / 8][7 - curPos % 8] = fastOut[0];
        if (curPos % 4 == 0)
          for (int m = 0; m < 11; m++)
            capByte[1 + m][curPos / 32][7 - (curPos / 4) % 8] = slowOut[m];
        if (curPos == FRAME - 1) begin
          scoreFrame(curFrame);
          curFrame++;
          curPos = 0;
        end else begin
          curPos++;
        end
      end else begin
        started  = 1;
        curFrame = 0;
        curPos   = 0;
      end
      frameSync = (curPos == 0);
      for (int i = 0; i < 2; i++) begin
        logic [7:0] b;
        b = dataOf(curFrame, i, curPos / 8);
        fastIn[i] = b[7 - curPos % 8];
      end
      for (int j = 0; j < 10; j++) begin
        logic [7:0] b;
        b = dataOf(curFrame, 2 + j, curPos / 32);
        slowIn[j] = b[7 - (curPos / 4) % 8];
      end
    end
  end

  task automatic writeConn(int op, int os, bit on, int sp, int ss);
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostWrAddr = 11'(op * 128 + os);
    hostWrOn   = on;
    hostWrSrc  = 11'(sp * 128 + ss);
    @(negedge clk);
    hostWrEn   = 1'b0;
  endtask

  task automatic expectConfigA(int f);
    expectRoute(f, 0, 10, 1, 100, "R3");
    expectRoute(f, 0, 127, 0, 0, "R3");
    expectRoute(f, 0, 0, 1, 127, "R2");
    expectRoute(f, 1, 31, 11, 31, "R2");
    expectRoute(f, 11, 31, 11, 0, "R4");
    expectRoute(f, 1, 0, 0, 127, "R5");
    expectRoute(f, 0, 64, 2, 31, "R5");
    expectRoute(f, 2, 3, 1, 50, "R8");
    expectRoute(f, 7, 30, 1, 50, "R8");
    expectRoute(f, 0, 5, 4, 31, "R7");
    expectRoute(f, 0, 120, 1, 2, "R7");
    expectIdle(f, 0, 11, "R6");
    expectIdle(f, 6, 0, "R6");
  endtask

  task automatic runAll();
    hostWrEn = 1'b0; hostWrAddr = '0; hostWrOn = 1'b0; hostWrSrc = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    testsRun++;
    if (fastOut !== 1'b0 || slowOut !== 11'h0) begin
      testsFailed++;
      $display("FAIL R1 outputs during reset: got %b %b expected 0 0", fastOut, slowOut);
    end
    expectIdle(0, 0, 0, "R1");
    expectIdle(0, 0, 127, "R6");
    expectIdle(0, 5, 31, "R1");
    @(posedge clk);
    rst <= 1'b0;

    wait (curFrame == 1);
    writeConn(0, 10, 1, 1, 100);
    writeConn(0, 127, 1, 0, 0);
    writeConn(0, 0, 1, 1, 127);
    writeConn(1, 31, 1, 11, 31);
    writeConn(3, 7, 1, 5, 20);
    writeConn(11, 31, 1, 11, 0);
    writeConn(1, 0, 1, 0, 127);
    writeConn(0, 64, 1, 2, 31);
    writeConn(2, 3, 1, 1, 50);
    writeConn(7, 30, 1, 1, 50);
    writeConn(0, 5, 1, 4, 31);
    writeConn(0, 120, 1, 1, 2);
    for (int f = 2; f <= 3; f++) begin
      expectConfigA(f);
      expectRoute(f, 3, 7, 5, 20, "R4");
    end

    wait (curFrame == 4);
    writeConn(0, 10, 0, 1, 100);
    writeConn(3, 7, 1, 6, 1);
    for (int f = 5; f <= 6; f++) begin
      expectRoute(f, 0, 127, 0, 0, "R3");
      expectRoute(f, 1, 0, 0, 127, "R5");
      expectRoute(f, 0, 5, 4, 31, "R7");
      expectIdle(f, 0, 10, "R9");
      expectRoute(f, 3, 7, 6, 1, "R9");
      expectRoute(f, 7, 30, 1, 50, "R8");
    end

    wait (curFrame == 7);
    repeat (4) @(negedge clk);
    testsRun++;
    if (sbq.size() != 0) begin
      testsFailed++;
      $display("FAIL R2 unscored expectations: got %0d expected 0", sbq.size());
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (WATCHDOG) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule